// File: doc/BRIEF.md
# Snoop Fan-out Order Tracker

This block sits inside a coherent interconnect between the masters that issue coherent requests and the snoop channels of those same masters. Each accepted request names the master that issued it and a line address. The block sends a snoop for that line to every other master and waits for each of them to answer. When all the snooped masters have answered, it reports the request as complete.

The snoop channel carries no transaction ID. A response therefore says only which master it comes from. The block keeps one small order queue per master. A slot is pushed when that master accepts a snoop, and the oldest slot is popped when that master responds. Each slot holds the tag of the originating request. A completion table counts the responses still owed per tag. A ring of tags in acceptance order makes completions come out in the order the requests went in. Backpressure on the request input holds the requester off while a fan-out is still being handed out, or while every tag is in use.

Top module: `snp_fanout_tracker`

## Requirements
- R1: After a clock edge with `rst_n` low, `req_ready` is 1, `snp_valid` is all zero, `cmp_valid` is 0 and `rsp_err` is all zero.
- R2: In the cycle after a request handshake, `snp_valid` bit i (bit i belongs to master i) is set for every master except `req_master`, provided that master's queue has room, and never for `req_master`. Slice `snp_addr[i*AW +: AW]` carries the request address.
- R3: Each snoop stays valid until its own master accepts it. A master that accepts early is not held back by one that accepts later.
- R4: `cmp_valid` rises in the cycle after the handshake of the last owed response, together with `cmp_master` and `cmp_addr`. It stays low while any snooped master has not yet answered.
- R5: Responses from one master are bound to that master's outstanding snoops strictly in issue order. The oldest snoop is answered first.
- R6: Completions are reported in the order the requests were accepted. A request whose responses are all in waits behind an older unfinished one, and then follows it on the next cycle.
- R7: `req_ready` is low from the cycle after a request handshake until every snoop of that request has been accepted.
- R8: While a master has DEPTH snoops outstanding, no further snoop is presented to it. The withheld snoop appears in the cycle after that master returns a response.
- R9: A response from a master with no outstanding snoop sets that master's `rsp_err` bit for one cycle in the next cycle. The response is dropped and changes no completion count.
- R10: At most REQ_DEPTH requests are accepted and not yet reported. At that limit `req_ready` is low. It returns high in the cycle after a completion is reported.
- R11: `rsp_ready` is held high for every master. Every response is taken, whether it matches a snoop or is dropped.
- R12: A reset during traffic clears all queues and the completion table. A response that arrives afterwards is treated as unmatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Coherent request present |
| req_ready | output | 1 | Request can be accepted |
| req_master | input | MW | Index of the requesting master |
| req_addr | input | AW | Line address of the request |
| snp_valid | output | N_MST | Snoop presented, one bit per master |
| snp_ready | input | N_MST | Master accepts its snoop |
| snp_addr | output | N_MST*AW | Snoop address, one AW slice per master |
| rsp_valid | input | N_MST | Snoop response, one bit per master |
| rsp_ready | output | N_MST | Response accepted (always high) |
| rsp_err | output | N_MST | Unmatched response seen, one-cycle pulse |
| cmp_valid | output | 1 | Request fully answered, oldest first |
| cmp_master | output | MW | Requesting master of the completed request |
| cmp_addr | output | AW | Address of the completed request |

## Verification
Two events can land on the same edge. One is a response that retires the last owed answer of one request. The other is the head completion being popped. The bench provokes this by answering two interleaved requests so that the younger one becomes complete on the edge that reports the older one. It then judges that the younger is reported exactly one cycle later and not lost. The same holds for a full queue. A response that frees a slot and the withheld snoop compete for that slot, and the bench checks that the snoop appears on the cycle right after the freeing response, and never while the queue is full.

// File: rtl/snp_pkg.sv
package snp_pkg;

    // width of a field that must hold values 0 .. n-1 (at least one bit)
    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // circular pointer advance over lim slots
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned lim);
        return (p + 1 >= lim) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/snp_order_fifo.sv
module snp_order_fifo
    import snp_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [TW-1:0] tag_i,
    input  logic          pop_i,
    output logic [TW-1:0] head_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int unsigned PW = bits_for(DEPTH);
    localparam int unsigned CW = bits_for(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] slot;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } ofifo_t;

    ofifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[st_q.wp] = tag_i;
            st_d.wp = PW'(ring_next(32'(st_q.wp), DEPTH));
        end
        if (pop_i) begin
            st_d.rp = PW'(ring_next(32'(st_q.rp), DEPTH));
        end
        st_d.cnt = st_q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.slot[st_q.rp];
    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);

endmodule

// File: rtl/snp_cmp_table.sv
module snp_cmp_table
    import snp_pkg::*;
#(
    parameter int unsigned N_MST     = 3,
    parameter int unsigned REQ_DEPTH = 6,
    parameter int unsigned AW        = 16,
    parameter int unsigned MW        = 2,
    parameter int unsigned TW        = 3,
    parameter int unsigned CW        = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_i,
    input  logic [CW-1:0]              alloc_cnt_i,
    input  logic [MW-1:0]              alloc_mst_i,
    input  logic [AW-1:0]              alloc_addr_i,
    output logic [TW-1:0]              alloc_tag_o,
    output logic                       full_o,
    input  logic [N_MST-1:0]           dec_i,
    input  logic [N_MST-1:0][TW-1:0]   dec_tag_i,
    output logic                       cmp_valid_o,
    output logic [MW-1:0]              cmp_mst_o,
    output logic [AW-1:0]              cmp_addr_o
);
    localparam int unsigned OW = bits_for(REQ_DEPTH + 1);

    typedef struct packed {
        logic [REQ_DEPTH-1:0][CW-1:0] owed;
        logic [REQ_DEPTH-1:0][MW-1:0] mst;
        logic [REQ_DEPTH-1:0][AW-1:0] adr;
        logic [TW-1:0]                wp;
        logic [TW-1:0]                rp;
        logic [OW-1:0]                occ;
    } ctab_t;

    ctab_t tb_d, tb_q;
    logic  head_done;

    always_comb begin
        logic [CW-1:0] hits;
        head_done = (tb_q.occ != '0) && (tb_q.owed[tb_q.rp] == '0);
        tb_d = tb_q;
        for (int t = 0; t < int'(REQ_DEPTH); t++) begin
            hits = '0;
            for (int m = 0; m < int'(N_MST); m++) begin
                if (dec_i[m] && (dec_tag_i[m] == TW'(t))) hits = hits + CW'(1);
            end
            tb_d.owed[t] = tb_q.owed[t] - hits;
        end
        if (alloc_i) begin
            tb_d.owed[tb_q.wp] = alloc_cnt_i;
            tb_d.mst[tb_q.wp]  = alloc_mst_i;
            tb_d.adr[tb_q.wp]  = alloc_addr_i;
            tb_d.wp = TW'(ring_next(32'(tb_q.wp), REQ_DEPTH));
        end
        if (head_done) begin
            tb_d.rp = TW'(ring_next(32'(tb_q.rp), REQ_DEPTH));
        end
        tb_d.occ = tb_q.occ + OW'(alloc_i) - OW'(head_done);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign alloc_tag_o = tb_q.wp;
    assign full_o      = (tb_q.occ == OW'(REQ_DEPTH));
    assign cmp_valid_o = head_done;
    assign cmp_mst_o   = tb_q.mst[tb_q.rp];
    assign cmp_addr_o  = tb_q.adr[tb_q.rp];

endmodule

// File: rtl/snp_fanout_tracker.sv
module snp_fanout_tracker
    import snp_pkg::*;
#(
    parameter  int unsigned N_MST     = 3,
    parameter  int unsigned DEPTH     = 4,
    parameter  int unsigned REQ_DEPTH = 6,
    parameter  int unsigned AW        = 16,
    localparam int unsigned MW        = bits_for(N_MST)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [MW-1:0]         req_master,
    input  logic [AW-1:0]         req_addr,
    output logic [N_MST-1:0]      snp_valid,
    input  logic [N_MST-1:0]      snp_ready,
    output logic [N_MST*AW-1:0]   snp_addr,
    input  logic [N_MST-1:0]      rsp_valid,
    output logic [N_MST-1:0]      rsp_ready,
    output logic [N_MST-1:0]      rsp_err,
    output logic                  cmp_valid,
    output logic [MW-1:0]         cmp_master,
    output logic [AW-1:0]         cmp_addr
);
    localparam int unsigned TW = bits_for(REQ_DEPTH);
    localparam int unsigned CW = bits_for(N_MST + 1);
    localparam logic [N_MST-1:0] ALL_M = '1;

    typedef struct packed {
        logic             busy;
        logic [N_MST-1:0] pend;
        logic [TW-1:0]    tag;
        logic [AW-1:0]    addr;
        logic [N_MST-1:0] err;
    } issue_t;

    issue_t iss_d, iss_q;

    logic [N_MST-1:0]         fifo_full;
    logic [N_MST-1:0]         fifo_empty;
    logic [N_MST-1:0][TW-1:0] head_tag;
    logic [N_MST-1:0]         push;
    logic [N_MST-1:0]         pop;
    logic [N_MST-1:0]         snp_valid_w;
    logic [N_MST-1:0]         new_mask;
    logic                     tbl_full;
    logic                     ready_w;
    logic                     accept;
    logic [TW-1:0]            alloc_tag;
    logic [CW-1:0]            alloc_cnt;

    always_comb begin
        snp_valid_w = iss_q.pend & ~fifo_full & {N_MST{iss_q.busy}};
        push        = snp_valid_w & snp_ready;
        pop         = rsp_valid & ~fifo_empty;
        ready_w     = !iss_q.busy && !tbl_full;
        accept      = req_valid && ready_w;
        new_mask    = ALL_M & ~(N_MST'(1) << req_master);
        alloc_cnt   = CW'($countones(new_mask));

        iss_d      = iss_q;
        iss_d.err  = rsp_valid & fifo_empty;
        iss_d.pend = iss_q.pend & ~push;
        if (accept) begin
            iss_d.pend = new_mask;
            iss_d.tag  = alloc_tag;
            iss_d.addr = req_addr;
        end
        iss_d.busy = |iss_d.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    generate
        for (genvar m = 0; m < int'(N_MST); m++) begin : g_mst
            snp_order_fifo #(
                .DEPTH (DEPTH),
                .TW    (TW)
            ) u_fifo (
                .clk     (clk),
                .rst_n   (rst_n),
                .push_i  (push[m]),
                .tag_i   (iss_q.tag),
                .pop_i   (pop[m]),
                .head_o  (head_tag[m]),
                .full_o  (fifo_full[m]),
                .empty_o (fifo_empty[m])
            );
            assign snp_addr[m*AW +: AW] = iss_q.addr;
        end
    endgenerate

    snp_cmp_table #(
        .N_MST     (N_MST),
        .REQ_DEPTH (REQ_DEPTH),
        .AW        (AW),
        .MW        (MW),
        .TW        (TW),
        .CW        (CW)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (accept),
        .alloc_cnt_i  (alloc_cnt),
        .alloc_mst_i  (req_master),
        .alloc_addr_i (req_addr),
        .alloc_tag_o  (alloc_tag),
        .full_o       (tbl_full),
        .dec_i        (pop),
        .dec_tag_i    (head_tag),
        .cmp_valid_o  (cmp_valid),
        .cmp_mst_o    (cmp_master),
        .cmp_addr_o   (cmp_addr)
    );

    assign req_ready = ready_w;
    assign snp_valid = snp_valid_w;
    assign rsp_ready = ALL_M;
    assign rsp_err   = iss_q.err;

endmodule

// File: rtl/snp_fanout_chk.sv
module snp_fanout_chk #(
    parameter int unsigned N_MST = 3,
    parameter int unsigned MW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [MW-1:0]    req_master,
    input logic [N_MST-1:0] snp_valid,
    input logic [N_MST-1:0] snp_ready,
    input logic [N_MST-1:0] rsp_valid,
    input logic [N_MST-1:0] rsp_err,
    input logic [N_MST-1:0] fifo_full,
    input logic [N_MST-1:0] fifo_empty,
    input logic             tbl_full
);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((snp_valid & snp_ready & fifo_full) == '0));

    // R2
    no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((snp_valid & (N_MST'(1) << $past(req_master))) == '0));

    // R7
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|snp_valid) |-> !req_ready);

    // R10
    tag_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_full |-> !req_ready);

    generate
        for (genvar m = 0; m < int'(N_MST); m++) begin : g_chk
            // R9
            drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid[m] && fifo_empty[m]) |=> rsp_err[m]);

            // R3
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (snp_valid[m] && !snp_ready[m]) |=> snp_valid[m]);
        end
    endgenerate

endmodule

bind snp_fanout_tracker snp_fanout_chk #(
    .N_MST (N_MST),
    .MW    (MW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_master (req_master),
    .snp_valid  (snp_valid),
    .snp_ready  (snp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .tbl_full   (tbl_full)
);

// File: tb/test_snp_fanout_tracker.sv
module test_snp_fanout_tracker;
    localparam int N  = 3;
    localparam int AW = 16;
    localparam int NV = 4;

    localparam logic [1:0]    VEC_M [NV] = '{2'd0, 2'd1, 2'd2, 2'd0};
    localparam logic [AW-1:0] VEC_A [NV] = '{16'h1234, 16'hABCD, 16'h0F0F, 16'hFFFF};
    localparam logic [N-1:0]  VEC_S [NV] = '{3'b110, 3'b101, 3'b011, 3'b110};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_master = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [N-1:0]    snp_valid;
    logic [N-1:0]    snp_ready = '0;
    logic [N*AW-1:0] snp_addr;
    logic [N-1:0]    rsp_valid = '0;
    logic [N-1:0]    rsp_ready;
    logic [N-1:0]    rsp_err;
    logic            cmp_valid;
    logic [1:0]      cmp_master;
    logic [AW-1:0]   cmp_addr;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    snp_fanout_tracker i_snp_fanout_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_master (req_master),
        .req_addr   (req_addr),
        .snp_valid  (snp_valid),
        .snp_ready  (snp_ready),
        .snp_addr   (snp_addr),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_err    (rsp_err),
        .cmp_valid  (cmp_valid),
        .cmp_master (cmp_master),
        .cmp_addr   (cmp_addr)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_req(input logic [1:0] m, input logic [AW-1:0] a);
        req_valid  = 1'b1;
        req_master = m;
        req_addr   = a;
        tick();
        req_valid  = 1'b0;
    endtask

    task automatic rsp1(input logic [N-1:0] mask);
        rsp_valid = mask;
        tick();
        rsp_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state, R11 response ready
        chk("R1 req_ready", req_ready, 1);
        chk("R1 snp_valid", snp_valid, 0);
        chk("R1 cmp_valid", cmp_valid, 0);
        chk("R1 rsp_err", rsp_err, 0);
        chk("R11 rsp_ready", rsp_ready, 3'b111);
        rst_n = 1'b1;
        tick();

        // table of single requests: R2 fan-out, R4 completion
        for (int i = 0; i < NV; i++) begin
            chk("R10 ready when free", req_ready, 1);
            send_req(VEC_M[i], VEC_A[i]);
            chk("R2 snoop mask", snp_valid, VEC_S[i]);
            for (int m = 0; m < N; m++)
                if (VEC_S[i][m]) chk("R2 snoop addr", snp_addr[m*AW +: AW], VEC_A[i]);
            chk("R7 held off", req_ready, 0);
            snp_ready = '1;
            tick();
            snp_ready = '0;
            chk("R3 all taken", snp_valid, 0);
            chk("R7 released", req_ready, 1);
            rsp1(VEC_S[i]);
            chk("R4 complete", cmp_valid, 1);
            chk("R4 master", cmp_master, VEC_M[i]);
            chk("R4 addr", cmp_addr, VEC_A[i]);
            tick();
            chk("R4 single pulse", cmp_valid, 0);
        end

        // R3 independent hand-over, R7 backpressure, R4 partial answers
        send_req(2'd0, 16'h2222);
        snp_ready = 3'b010;
        tick();
        chk("R3 other still valid", snp_valid, 3'b100);
        chk("R7 stall", req_ready, 0);
        tick();
        chk("R3 still held", snp_valid, 3'b100);
        chk("R7 stall 2", req_ready, 0);
        snp_ready = 3'b100;
        tick();
        snp_ready = '0;
        chk("R3 done", snp_valid, 0);
        chk("R7 free", req_ready, 1);
        rsp1(3'b010);
        chk("R4 not early", cmp_valid, 0);
        rsp1(3'b100);
        chk("R4 last answer", cmp_valid, 1);
        chk("R4 addr partial", cmp_addr, 16'h2222);
        tick();

        // R5 per-master issue order binding
        snp_ready = '1;
        send_req(2'd0, 16'h0A0A);
        tick();
        send_req(2'd2, 16'h0B0B);
        tick();
        snp_ready = '0;
        rsp1(3'b001);
        chk("R5 none yet a", cmp_valid, 0);
        rsp1(3'b010);
        chk("R5 none yet b", cmp_valid, 0);
        rsp1(3'b100);
        chk("R5 oldest bound", cmp_valid, 1);
        chk("R5 oldest addr", cmp_addr, 16'h0A0A);
        rsp1(3'b010);
        chk("R5 second bound", cmp_valid, 1);
        chk("R5 second addr", cmp_addr, 16'h0B0B);
        tick();
        chk("R5 drained", cmp_valid, 0);

        // R6 completion in acceptance order
        snp_ready = '1;
        send_req(2'd0, 16'h0C0C);
        tick();
        send_req(2'd1, 16'h0D0D);
        tick();
        snp_ready = '0;
        rsp1(3'b001);
        chk("R6 wait a", cmp_valid, 0);
        rsp1(3'b100);
        chk("R6 wait b", cmp_valid, 0);
        rsp1(3'b100);
        chk("R6 younger waits", cmp_valid, 0);
        rsp1(3'b010);
        chk("R6 older first", cmp_valid, 1);
        chk("R6 older addr", cmp_addr, 16'h0C0C);
        tick();
        chk("R6 younger next", cmp_valid, 1);
        chk("R6 younger addr", cmp_addr, 16'h0D0D);
        chk("R6 younger master", cmp_master, 1);
        tick();
        chk("R6 drained", cmp_valid, 0);

        // R8 full per-master queue
        snp_ready = '1;
        for (int i = 0; i < 4; i++) begin
            send_req(2'd0, 16'h1000 + 16'(i));
            tick();
        end
        send_req(2'd1, 16'h5555);
        chk("R8 withheld", snp_valid, 3'b001);
        tick();
        chk("R8 still withheld", snp_valid, 3'b000);
        chk("R8 stall", req_ready, 0);
        rsp1(3'b100);
        chk("R8 freed", snp_valid, 3'b100);
        tick();
        chk("R8 issued", snp_valid, 3'b000);
        chk("R8 ready back", req_ready, 1);
        snp_ready = '0;

        // R12 reset during traffic
        rst_n = 1'b0;
        tick();
        chk("R12 req_ready", req_ready, 1);
        chk("R12 snp_valid", snp_valid, 0);
        chk("R12 cmp_valid", cmp_valid, 0);
        rst_n = 1'b1;
        rsp1(3'b001);
        chk("R12 queue cleared", rsp_err, 3'b001);
        chk("R12 no completion", cmp_valid, 0);
        tick();

        // R9 unmatched response
        rsp1(3'b010);
        chk("R9 err flag", rsp_err, 3'b010);
        chk("R9 no completion", cmp_valid, 0);
        tick();
        chk("R9 pulse", rsp_err, 0);
        snp_ready = '1;
        send_req(2'd2, 16'h7777);
        tick();
        snp_ready = '0;
        rsp1(3'b001);
        chk("R9 not counted", cmp_valid, 0);
        rsp1(3'b010);
        chk("R9 normal after drop", cmp_valid, 1);
        chk("R9 addr", cmp_addr, 16'h7777);
        tick();

        // R10 tag limit
        snp_ready = '1;
        for (int i = 0; i < 6; i++) begin
            send_req(2'(i % 3), 16'h3000 + 16'(i));
            tick();
        end
        chk("R10 limit", req_ready, 0);
        req_valid = 1'b1;
        req_master = 2'd1;
        tick();
        tick();
        req_valid = 1'b0;
        chk("R10 nothing taken", snp_valid, 0);
        rsp1(3'b110);
        chk("R10 head done", cmp_valid, 1);
        chk("R10 head addr", cmp_addr, 16'h3000);
        chk("R10 still full", req_ready, 0);
        tick();
        chk("R10 slot freed", req_ready, 1);
        snp_ready = '0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule